// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block is the register bank behind the management port of a gigabit Ethernet PHY. A management agent (for example a serial management engine elsewhere in the chip) reaches it through a 5-bit register address and two strobes, one for reads and one for writes. Each cycle allows one read, one write or both. Read data is registered and is valid one cycle after the read strobe. Each address has a fixed access policy: read-write, read-only, write-only, reads-as-zero, or absent.

The bank also carries the link behaviour that software relies on. A level input from the line side reports whether the link is up. A rising or falling edge on that input updates the PHY-specific status register and the basic status register. The link-status bit in the basic status register is latched low, so a link drop stays visible until software reads the register. Writing the control register with its reset bit set starts a soft reset instead of storing the value. The soft reset clears selected state and pulses a link-reset output for one cycle. A link-up output follows the live link bit.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hard reset, reads return control 0x1140 (bit 6 speed MSB, bit 8 duplex, bit 12 auto-negotiation enable), status 0x7949, identifier 0x0141, extended identifier EXT_ID (default 0x0000), advertisement 0x01E1, partner ability 0x01E0, gigabit control 0x1E00, specific control 0x0068 and specific status 0x0000. `link_up` and `link_rst_pulse` are low.
- R2: `rdata` is updated only at a clock edge where `rd_en` is high. It then shows the addressed value from before that edge, and it holds that value while no read is made.
- R3: Addresses 0 (when wdata bit 15 is 0), 4 and 16 store the written 16-bit value.
- R4: Addresses 1, 2, 3, 5, 9, 10 and 17 are read-only. A write to any of them changes no register.
- R5: Addresses 6, 7, 8, 15, 18, 19, 20, 21, 26 and 30, write-only address 29, and the absent addresses (11 to 14, 22 to 25, 27, 28, 31) all read 0. Writes to them have no effect.
- R6: Address 10 always reads 0x3C00.
- R7: A write to address 0 with wdata bit 15 set does not store wdata. Instead, control becomes its old value ANDed with 0x3140, status returns to 0x7949, and specific status is ANDed with 0xE001.
- R8: A rising edge on `link_in` ORs 0xAC00 into specific status and sets status bit 5 (negotiation complete). Status bit 2 is left unchanged. `link_up` is high one clock edge later.
- R9: A falling edge on `link_in` clears bits 0xAC00 of specific status and clears status bits 2 and 5. `link_up` is low one clock edge later.
- R10: A read of address 1 returns the latched bit 2. The same edge then reloads bit 2 from specific status bit 10, so after a link rise the first status read shows 0x7969 and the second shows 0x796D.
- R11: `link_rst_pulse` is high for exactly the one cycle after a soft-reset write, and never otherwise. `link_up` always equals specific status bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| link_in | input | 1 | Line-side link level |
| link_up | output | 1 | Live link indication |
| link_rst_pulse | output | 1 | One-cycle link reset request |

## Verification
Every result is due one clock edge after its stimulus. Read data appears at the edge that samples `rd_en`. Link bits and `link_up` change at the edge that first sees `link_in` change. The reset pulse rises at the edge that takes the soft-reset write.

The bench drives inputs on the falling edge and compares on the next falling edge. Its scoreboard monitor records at each rising edge whether a read was taken, and pops the expected value only half a cycle later. Link stimulus is never given in the same cycle as a status read, so the latched-low order can be predicted exactly.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;

  typedef logic [REG_W-1:0]  word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    ACC_RW,
    ACC_RO,
    ACC_WO,
    ACC_ZERO,
    ACC_ABSENT
  } acc_e;

  typedef enum logic [3:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_ID,
    SEL_EXTID,
    SEL_ADV,
    SEL_PARTNER,
    SEL_GCTRL,
    SEL_GSTAT,
    SEL_SCTRL,
    SEL_SSTAT,
    SEL_NONE
  } sel_e;

  // Bit positions that behaviour depends on
  localparam int CTRL_RST_BIT = 15;
  localparam int STAT_LNK_BIT = 2;
  localparam int STAT_NEG_BIT = 5;
  localparam int SSTAT_LIVE_BIT = 10;

  // Reset and constant values
  localparam word_t CTRL_INIT    = 16'h1140;
  localparam word_t CTRL_KEEP    = 16'h3140;
  localparam word_t STAT_BASE    = 16'h7949;
  localparam word_t ID_VAL       = 16'h0141;
  localparam word_t ADV_INIT     = 16'h01E1;
  localparam word_t PARTNER_VAL  = 16'h01E0;
  localparam word_t GCTRL_VAL    = 16'h1E00;
  localparam word_t GSTAT_VAL    = 16'h3C00;
  localparam word_t SCTRL_INIT   = 16'h0068;
  localparam word_t SSTAT_LINKS  = 16'hAC00;
  localparam word_t SSTAT_KEEP   = 16'hE001;

  function automatic sel_e sel_of(input addr_t a);
    case (a)
      5'd0:    return SEL_CTRL;
      5'd1:    return SEL_STAT;
      5'd2:    return SEL_ID;
      5'd3:    return SEL_EXTID;
      5'd4:    return SEL_ADV;
      5'd5:    return SEL_PARTNER;
      5'd9:    return SEL_GCTRL;
      5'd10:   return SEL_GSTAT;
      5'd16:   return SEL_SCTRL;
      5'd17:   return SEL_SSTAT;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic acc_e acc_of(input addr_t a);
    case (a)
      5'd0, 5'd4, 5'd16:                          return ACC_RW;
      5'd1, 5'd2, 5'd3, 5'd5, 5'd9, 5'd10, 5'd17: return ACC_RO;
      5'd29:                                      return ACC_WO;
      5'd6, 5'd7, 5'd8, 5'd15, 5'd18, 5'd19,
      5'd20, 5'd21, 5'd26, 5'd30:                 return ACC_ZERO;
      default:                                    return ACC_ABSENT;
    endcase
  endfunction

endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
  import phy_mgmt_pkg::*;
(
  input  addr_t addr,
  output sel_e  sel,
  output logic  wr_allowed,
  output logic  rd_visible
);

  acc_e acc;

  always_comb begin
    acc        = acc_of(addr);
    sel        = sel_of(addr);
    wr_allowed = (acc == ACC_RW);
    rd_visible = (acc == ACC_RW) || (acc == ACC_RO);
  end

endmodule

// File: rtl/phy_mgmt_link.sv
module phy_mgmt_link (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic up_evt,
  output logic dn_evt
);

  logic seen_q;
  logic seen_d;

  always_comb begin
    seen_d = link_in;
    up_evt = link_in && !seen_q;
    dn_evt = !link_in && seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
    end
  end

endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] EXT_ID = 16'h0000
) (
  input  sel_e  sel,
  input  logic  visible,
  input  word_t ctrl,
  input  logic  stat_lnk,
  input  logic  stat_neg,
  input  word_t adv,
  input  word_t sctrl,
  input  word_t sstat,
  output word_t value
);

  word_t stat_word;

  always_comb begin
    stat_word = STAT_BASE;
    stat_word[STAT_LNK_BIT] = stat_lnk;
    stat_word[STAT_NEG_BIT] = stat_neg;

    value = '0;
    if (visible) begin
      case (sel)
        SEL_CTRL:    value = ctrl;
        SEL_STAT:    value = stat_word;
        SEL_ID:      value = ID_VAL;
        SEL_EXTID:   value = EXT_ID;
        SEL_ADV:     value = adv;
        SEL_PARTNER: value = PARTNER_VAL;
        SEL_GCTRL:   value = GCTRL_VAL;
        SEL_GSTAT:   value = GSTAT_VAL;
        SEL_SCTRL:   value = sctrl;
        SEL_SSTAT:   value = sstat;
        default:     value = '0;
      endcase
    end
  end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] EXT_ID = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        link_in,
  output logic        link_up,
  output logic        link_rst_pulse
);

  sel_e  sel;
  logic  wr_allowed;
  logic  rd_visible;
  logic  up_evt;
  logic  dn_evt;
  word_t rd_val;

  word_t ctrl_q,  ctrl_d;
  word_t adv_q,   adv_d;
  word_t sctrl_q, sctrl_d;
  word_t sstat_q, sstat_d;
  logic  lnk_q,   lnk_d;
  logic  neg_q,   neg_d;
  word_t rdata_q, rdata_d;
  logic  pulse_q, pulse_d;

  logic  wr_hit;
  logic  soft_rst;
  logic  stat_read;
  logic  rdata_en;

  phy_mgmt_decode u_decode (
    .addr       (addr),
    .sel        (sel),
    .wr_allowed (wr_allowed),
    .rd_visible (rd_visible)
  );

  phy_mgmt_link u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_in (link_in),
    .up_evt  (up_evt),
    .dn_evt  (dn_evt)
  );

  phy_mgmt_rdmux #(.EXT_ID(EXT_ID)) u_rdmux (
    .sel      (sel),
    .visible  (rd_visible),
    .ctrl     (ctrl_q),
    .stat_lnk (lnk_q),
    .stat_neg (neg_q),
    .adv      (adv_q),
    .sctrl    (sctrl_q),
    .sstat    (sstat_q),
    .value    (rd_val)
  );

  // Next-state logic
  always_comb begin
    wr_hit    = wr_en && wr_allowed;
    soft_rst  = wr_hit && (sel == SEL_CTRL) && wdata[CTRL_RST_BIT];
    stat_read = rd_en && (sel == SEL_STAT);
    rdata_en  = rd_en;

    ctrl_d  = ctrl_q;
    adv_d   = adv_q;
    sctrl_d = sctrl_q;
    sstat_d = sstat_q;
    lnk_d   = lnk_q;
    neg_d   = neg_q;

    // Register writes
    if (wr_hit && !soft_rst) begin
      case (sel)
        SEL_CTRL:  ctrl_d  = wdata;
        SEL_ADV:   adv_d   = wdata;
        SEL_SCTRL: sctrl_d = wdata;
        default:   ;
      endcase
    end

    // Latched-low refresh after a status read
    if (stat_read) begin
      lnk_d = sstat_q[SSTAT_LIVE_BIT];
    end

    // Soft reset
    if (soft_rst) begin
      ctrl_d  = ctrl_q & CTRL_KEEP;
      lnk_d   = 1'b0;
      neg_d   = 1'b0;
      sstat_d = sstat_q & SSTAT_KEEP;
    end

    // Line-side link events take effect last
    if (up_evt) begin
      sstat_d = sstat_d | SSTAT_LINKS;
      neg_d   = 1'b1;
    end else if (dn_evt) begin
      sstat_d = sstat_d & ~SSTAT_LINKS;
      lnk_d   = 1'b0;
      neg_d   = 1'b0;
    end

    rdata_d = rdata_en ? rd_val : rdata_q;
    pulse_d = soft_rst;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_INIT;
      adv_q   <= ADV_INIT;
      sctrl_q <= SCTRL_INIT;
      sstat_q <= '0;
      lnk_q   <= 1'b0;
      neg_q   <= 1'b0;
      rdata_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      adv_q   <= adv_d;
      sctrl_q <= sctrl_d;
      sstat_q <= sstat_d;
      lnk_q   <= lnk_d;
      neg_q   <= neg_d;
      rdata_q <= rdata_d;
      pulse_q <= pulse_d;
    end
  end

  assign rdata          = rdata_q;
  assign link_up        = sstat_q[SSTAT_LIVE_BIT];
  assign link_rst_pulse = pulse_q;

endmodule

// File: rtl/phy_mgmt_regs_checker.sv
module phy_mgmt_regs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [4:0]  addr,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic        link_in,
  input logic        link_up,
  input logic        link_rst_pulse
);

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_id_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 5'd2) |=> (rdata == 16'h0141));

  assert_hole_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 5'd6 || addr == 5'd29 || addr == 5'd31)) |=> (rdata == 16'h0000));

  assert_gstat_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 5'd10) |=> (rdata == 16'h3C00));

  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'd0 && wdata[15]) |=> link_rst_pulse);

  assert_link_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_in) |=> link_up);

  assert_link_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_in) |=> !link_up);

  assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst_pulse |-> $past(wr_en && addr == 5'd0 && wdata[15]));

endmodule

bind phy_mgmt_regs phy_mgmt_regs_checker u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_en          (rd_en),
  .wr_en          (wr_en),
  .addr           (addr),
  .wdata          (wdata),
  .rdata          (rdata),
  .link_in        (link_in),
  .link_up        (link_up),
  .link_rst_pulse (link_rst_pulse)
);

// File: tb/phy_mgmt_regs_test.sv
`timescale 1ns/1ps
module phy_mgmt_regs_test;

  logic        clk;
  logic        rst_n;
  logic        rd_en;
  logic        wr_en;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        link_in;
  logic        link_up;
  logic        link_rst_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] exp;
    logic [4:0]  a;
    string       tag;
  } item_t;

  item_t sb[$];
  logic  read_due;

  phy_mgmt_regs uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_en          (rd_en),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .rdata          (rdata),
    .link_in        (link_in),
    .link_up        (link_up),
    .link_rst_pulse (link_rst_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: record at the edge whether a read was taken, compare half a cycle later
  always @(posedge clk) read_due <= rd_en;

  always @(negedge clk) begin
    if (rst_n && read_due) begin
      if (sb.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2: read result with no expected item");
      end else begin
        item_t it;
        it = sb.pop_front();
        check($sformatf("%s addr %0d", it.tag, it.a), rdata, it.exp);
      end
    end
  end

  // Driver tasks: called right after a falling edge
  task automatic do_read(input logic [4:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.a   = a;
    it.tag = tag;
    sb.push_back(it);
    rd_en = 1'b1;
    addr  = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_link(input logic v);
    link_in = v;
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    rd_en   = 1'b0;
    wr_en   = 1'b0;
    addr    = '0;
    wdata   = '0;
    link_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 link_up", {15'd0, link_up}, 16'd0);
    check("R1 pulse", {15'd0, link_rst_pulse}, 16'd0);
    do_read(5'd0,  16'h1140, "R1");
    do_read(5'd1,  16'h7949, "R1");
    do_read(5'd2,  16'h0141, "R1");
    do_read(5'd3,  16'h0000, "R1");
    do_read(5'd4,  16'h01E1, "R1");
    do_read(5'd5,  16'h01E0, "R1");
    do_read(5'd9,  16'h1E00, "R1");
    do_read(5'd16, 16'h0068, "R1");
    do_read(5'd17, 16'h0000, "R1");

    // R6: fixed gigabit status
    do_read(5'd10, 16'h3C00, "R6");

    // R2: rdata holds while idle
    repeat (3) @(negedge clk);
    check("R2 hold", rdata, 16'h3C00);

    // R5: holes, write-only and absent addresses
    do_write(5'd29, 16'hFFFF);
    do_write(5'd30, 16'hFFFF);
    do_write(5'd7,  16'hFFFF);
    do_write(5'd12, 16'hFFFF);
    foreach (sb[i]) ;
    begin
      int hole [14] = '{6, 7, 8, 15, 18, 19, 20, 21, 26, 29, 30, 11, 12, 31};
      foreach (hole[i]) do_read(hole[i][4:0], 16'h0000, "R5");
    end
    do_read(5'd0, 16'h1140, "R5 ctrl untouched");

    // R3: read-write registers
    do_write(5'd4, 16'h0DE1);
    do_read(5'd4, 16'h0DE1, "R3");
    do_write(5'd16, 16'h0078);
    do_read(5'd16, 16'h0078, "R3");
    do_write(5'd0, 16'h2100);
    do_read(5'd0, 16'h2100, "R3");

    // R4: read-only registers ignore writes
    do_write(5'd1,  16'hFFFF);
    do_write(5'd2,  16'h0000);
    do_write(5'd3,  16'hFFFF);
    do_write(5'd5,  16'h0000);
    do_write(5'd9,  16'h0000);
    do_write(5'd10, 16'h0000);
    do_write(5'd17, 16'hFFFF);
    do_read(5'd1,  16'h7949, "R4");
    do_read(5'd2,  16'h0141, "R4");
    do_read(5'd3,  16'h0000, "R4");
    do_read(5'd5,  16'h01E0, "R4");
    do_read(5'd9,  16'h1E00, "R4");
    do_read(5'd10, 16'h3C00, "R4");
    do_read(5'd17, 16'h0000, "R4");
    check("R4 link_up", {15'd0, link_up}, 16'd0);

    // R8 and R10: link rise, latched-low status
    set_link(1'b1);
    check("R8 link_up", {15'd0, link_up}, 16'd1);
    do_read(5'd17, 16'hAC00, "R8");
    do_read(5'd1,  16'h7969, "R10 first");
    do_read(5'd1,  16'h796D, "R10 second");

    // R9: link fall
    set_link(1'b0);
    check("R9 link_up", {15'd0, link_up}, 16'd0);
    do_read(5'd1,  16'h7949, "R9");
    do_read(5'd17, 16'h0000, "R9");

    // R10: rise again, latch starts low
    set_link(1'b1);
    do_read(5'd1, 16'h7969, "R10 again");
    do_read(5'd1, 16'h796D, "R10 again");

    // R11: plain control write gives no pulse
    do_write(5'd0, 16'h7FFF);
    check("R11 no pulse", {15'd0, link_rst_pulse}, 16'd0);
    do_read(5'd0, 16'h7FFF, "R3");

    // R7: soft reset
    do_write(5'd0, 16'h8000);
    check("R7 pulse", {15'd0, link_rst_pulse}, 16'd1);
    @(negedge clk);
    check("R11 pulse width", {15'd0, link_rst_pulse}, 16'd0);
    check("R7 link_up", {15'd0, link_up}, 16'd0);
    do_read(5'd0,  16'h3140, "R7");
    do_read(5'd1,  16'h7949, "R7");
    do_read(5'd17, 16'hA000, "R7");
    do_read(5'd4,  16'h0DE1, "R7 adv kept");

    repeat (2) @(negedge clk);
    check("R2 queue drained", 16'(sb.size()), 16'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule